// File: doc/BRIEF.md
# Codirectional Receive Octet Aligner

This block sits behind a line interface that turns a 64 kbit/s codirectional signal into two active-low rail pins, one per polarity. A recovered 128 kHz clock samples the rails twice per bit. The block decodes each bit from its two half-bit samples. It treats a mark that repeats the polarity of the mark before it as the marker of an octet's final bit, and it gathers the bits into octets.

Finished octets go into one of two storage registers, used in turn. A local 2.048 MHz clock reads the registers back out as an eight-bit burst inside a time-slot envelope. The envelope is picked from two hard-wired candidates. If the two clock rates drift apart, whole octets are repeated or dropped, and a flag marks each such frame.

The block keeps its framing running when the markers stop. It can blank the octets that lack a marker. It raises an alarm when markers have been missing for too long, and a separate input forces the output to ones.

Top module: `codir_rx_aligner`

## Requirements
- R1: While reset is asserted and until the first burst, `pcmOut` is 1, and `alarm`, `repeatFlag` and `deleteFlag` are 0. Both storage registers start as all ones.
- R2: The rail pins are active low. The rail that is low at the first half-bit sample carries the bit. A mark on that rail at both half-bit samples decodes as 0, and a mark at the first sample only decodes as 1. The first bit received on the line is the first bit sent in the burst.
- R3: The burst starts at the first `pcmClk` rising edge at which the selected envelope is sampled high. At that edge `pcmOut` takes octet bit 0, and the next seven rising edges give bits 1 to 7. At every other time `pcmOut` is 1.
- R4: When `envSelA` is 1, `envA` is the envelope and `envB` is ignored. When `envSelA` is 0, `envB` is the envelope and `envA` is ignored.
- R5: A bit whose mark repeats the rail of the previous mark closes the current octet. With no such bit, an octet closes on the eighth bit counted from the last boundary, so framing coasts on the last marker.
- R6: An octet that closes without a marker is stored as all ones when `holdOnMiss` is 0. It is stored unchanged when `holdOnMiss` is 1.
- R7: `alarm` goes to 1 when the eighth consecutive octet closes without a marker. It returns to 0 when the next octet closes on a marker.
- R8: While `forceOnes` is 1, `pcmOut` is 1.
- R9: If no new octet has been stored since the previous burst, the burst repeats the previous octet and `repeatFlag` is 1 from its first bit until the next burst starts.
- R10: A burst always carries the newest stored octet. With one new octet since the last burst both flags are 0. With two or more, the older ones are dropped and `deleteFlag` is 1 for that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lineClk | input | 1 | Recovered 128 kHz sampling clock, two samples per bit |
| pcmClk | input | 1 | Local 2.048 MHz time-slot clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| railPosN | input | 1 | Positive-polarity rail, active low |
| railNegN | input | 1 | Negative-polarity rail, active low |
| holdOnMiss | input | 1 | 1 lets octets without a marker pass unblanked |
| forceOnes | input | 1 | 1 forces `pcmOut` high |
| envA | input | 1 | Candidate time-slot envelope A |
| envB | input | 1 | Candidate time-slot envelope B |
| envSelA | input | 1 | 1 selects `envA`, 0 selects `envB` |
| pcmOut | output | 1 | Serial time-slot data, idle high |
| alarm | output | 1 | Markers missing for the configured count (line domain) |
| repeatFlag | output | 1 | Current burst repeats the previous octet |
| deleteFlag | output | 1 | Octets were dropped before the current burst |

## Verification
The bench runs bursts faster than octets arrive, which forces repeats, and slower than octets arrive, which forces drops. A design that counted handovers wrongly would deliver a stale or skipped octet without raising the matching flag. Envelope pulses are sent on the unselected input, and a broken multiplexer would answer them with data. Octets without markers are sent under both blanking settings and across the eighth-miss boundary. A design with an off-by-one miss counter, or one that lost framing when markers stopped, would misreport the alarm or garble the data. The all-zero and all-one octets check the half-bit decoding at both extremes.

// File: rtl/codir_rx_pkg.sv
package codir_rx_pkg;
  localparam int OCT_W     = 8;
  localparam int BIT_IDX_W = $clog2(OCT_W);

  // line-domain strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // a decoded bit is ready
    logic bitVal;    // its value
    logic commit;    // this bit closes the octet
    logic blankOct;  // store the closing octet as all ones
  } lineStrobe_t;

  // pcm-domain strobes from control to datapath
  typedef struct packed {
    logic                 drive;   // put a buffer bit on the output this edge
    logic                 rdSel;   // which storage register
    logic [BIT_IDX_W-1:0] bitIdx;  // which bit of it
  } slotStrobe_t;
endpackage

// File: rtl/codir_line_ctrl.sv
module codir_line_ctrl
  import codir_rx_pkg::*;
#(
  parameter int MISS_LIMIT = 8
) (
  input  logic        lineClk,
  input  logic        rstN,
  input  logic        railPosN,
  input  logic        railNegN,
  input  logic        holdOnMiss,
  output lineStrobe_t strobe,
  output logic        alarm
);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [MISS_W-1:0]    MISS_TOP = MISS_W'(MISS_LIMIT);
  localparam logic [BIT_IDX_W-1:0] LAST_POS = BIT_IDX_W'(OCT_W - 1);

  logic posMark, negMark;
  assign posMark = ~railPosN;
  assign negMark = ~railNegN;

  logic secondHalf, headRail, prevRail, railKnown;
  logic bitRdy, bitVal, bitViol;
  logic [BIT_IDX_W-1:0] bitCnt;
  logic [MISS_W-1:0]    missCnt;
  logic octetEnd;

  // half-bit decoder: waits for a mark to open a bit
  always_ff @(posedge lineClk or negedge rstN) begin
    if (!rstN) begin
      secondHalf <= 1'b0;
      headRail   <= 1'b0;
      prevRail   <= 1'b0;
      railKnown  <= 1'b0;
      bitRdy     <= 1'b0;
      bitVal     <= 1'b0;
      bitViol    <= 1'b0;
    end else begin
      bitRdy <= 1'b0;
      if (!secondHalf) begin
        if (posMark | negMark) begin
          secondHalf <= 1'b1;
          headRail   <= posMark;
        end
      end else begin
        secondHalf <= 1'b0;
        bitRdy     <= 1'b1;
        bitVal     <= ~(headRail ? posMark : negMark);
        bitViol    <= railKnown && (headRail == prevRail);
        prevRail   <= headRail;
        railKnown  <= 1'b1;
      end
    end
  end

  assign octetEnd = bitRdy & (bitViol | (bitCnt == LAST_POS));

  // octet framing with flywheel and miss counter
  always_ff @(posedge lineClk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      missCnt <= '0;
    end else begin
      if (bitRdy) bitCnt <= octetEnd ? '0 : bitCnt + BIT_IDX_W'(1);
      if (octetEnd) begin
        if (bitViol)                missCnt <= '0;
        else if (missCnt != MISS_TOP) missCnt <= missCnt + MISS_W'(1);
      end
    end
  end

  assign alarm = (missCnt == MISS_TOP);

  always_comb begin
    strobe.shiftIn  = bitRdy;
    strobe.bitVal   = bitVal;
    strobe.commit   = octetEnd;
    strobe.blankOct = octetEnd & ~bitViol & ~holdOnMiss;
  end

  AST_ALARM_RISE: assert property (@(posedge lineClk) disable iff (!rstN)
    $rose(alarm) |-> $past(strobe.commit && !bitViol)); // R7
  AST_ALARM_CLEAR: assert property (@(posedge lineClk) disable iff (!rstN)
    (strobe.commit && bitViol) |=> !alarm); // R7
endmodule

// File: rtl/codir_slot_ctrl.sv
module codir_slot_ctrl
  import codir_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        pcmClk,
  input  logic        rstN,
  input  logic        envA,
  input  logic        envB,
  input  logic        envSelA,
  input  logic        wrTog,
  output slotStrobe_t strobe,
  output logic        repeatFlag,
  output logic        deleteFlag
);
  localparam logic [BIT_IDX_W-1:0] LAST_POS = BIT_IDX_W'(OCT_W - 1);

  logic [SYNC_STAGES-1:0] togSync;
  logic togSeen, togNow, togEdge;
  logic envCur, envPrev, frameStart;
  logic [1:0] pendCnt;
  logic [2:0] effPend;
  logic rdIdx, startSel, inBurst;
  logic [BIT_IDX_W-1:0] bitIdx;

  always_ff @(posedge pcmClk or negedge rstN) begin
    if (!rstN) togSync <= '0;
    else       togSync <= {togSync[SYNC_STAGES-2:0], wrTog};
  end

  assign togNow     = togSync[SYNC_STAGES-1];
  assign togEdge    = togNow ^ togSeen;
  assign envCur     = envSelA ? envA : envB;
  assign frameStart = envCur & ~envPrev;
  assign effPend    = {1'b0, pendCnt} + {2'b00, togEdge};
  // the register written last is the one the toggle no longer points at
  assign startSel   = (effPend != 3'd0) ? ~togNow : rdIdx;

  always_ff @(posedge pcmClk or negedge rstN) begin
    if (!rstN) begin
      togSeen    <= 1'b0;
      envPrev    <= 1'b0;
      pendCnt    <= '0;
      rdIdx      <= 1'b0;
      inBurst    <= 1'b0;
      bitIdx     <= '0;
      repeatFlag <= 1'b0;
      deleteFlag <= 1'b0;
    end else begin
      togSeen <= togNow;
      envPrev <= envCur;
      if (frameStart) begin
        pendCnt    <= '0;
        rdIdx      <= startSel;
        repeatFlag <= (effPend == 3'd0);
        deleteFlag <= (effPend >= 3'd2);
        bitIdx     <= BIT_IDX_W'(1);
        inBurst    <= 1'b1;
      end else begin
        if (togEdge && pendCnt != 2'd3) pendCnt <= pendCnt + 2'd1;
        if (inBurst && envCur) begin
          bitIdx <= bitIdx + BIT_IDX_W'(1);
          if (bitIdx == LAST_POS) inBurst <= 1'b0;
        end else begin
          inBurst <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strobe.drive  = frameStart | (inBurst & envCur);
    strobe.rdSel  = frameStart ? startSel : rdIdx;
    strobe.bitIdx = frameStart ? '0 : bitIdx;
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge pcmClk) disable iff (!rstN)
    !(repeatFlag && deleteFlag)); // R10
  AST_BURST_ORDER: assert property (@(posedge pcmClk) disable iff (!rstN)
    (strobe.drive && !frameStart) |-> (strobe.bitIdx == BIT_IDX_W'($past(strobe.bitIdx) + 1'b1))); // R3
endmodule

// File: rtl/codir_octet_path.sv
module codir_octet_path
  import codir_rx_pkg::*;
(
  input  logic        lineClk,
  input  logic        pcmClk,
  input  logic        rstN,
  input  lineStrobe_t lStb,
  input  slotStrobe_t sStb,
  input  logic        forceOnes,
  output logic        wrTog,
  output logic        pcmOut
);
  logic [OCT_W-1:0] shReg, nextOct;
  logic [OCT_W-1:0] bufView [2];
  logic wrIdx, pcmOutR;

  assign nextOct = {lStb.bitVal, shReg[OCT_W-1:1]};

  always_ff @(posedge lineClk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      wrIdx <= 1'b0;
    end else begin
      if (lStb.shiftIn) shReg <= nextOct;
      if (lStb.commit)  wrIdx <= ~wrIdx;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gStore
    logic [OCT_W-1:0] store;
    always_ff @(posedge lineClk or negedge rstN) begin
      if (!rstN) store <= '1;
      else if (lStb.commit && (wrIdx == 1'(g)))
        store <= lStb.blankOct ? '1 : nextOct;
    end
    assign bufView[g] = store;
  end

  assign wrTog = wrIdx;

  always_ff @(posedge pcmClk or negedge rstN) begin
    if (!rstN) pcmOutR <= 1'b1;
    else       pcmOutR <= forceOnes | ~sStb.drive | bufView[sStb.rdSel][sStb.bitIdx];
  end

  assign pcmOut = pcmOutR;

  AST_BLANKED_OCTET: assert property (@(posedge lineClk) disable iff (!rstN)
    (lStb.commit && lStb.blankOct) |=> (bufView[$past(wrIdx)] == '1)); // R6
  AST_FORCE_ONES: assert property (@(posedge pcmClk) disable iff (!rstN)
    $past(forceOnes) |-> pcmOut); // R8
endmodule

// File: rtl/codir_rx_aligner.sv
module codir_rx_aligner
  import codir_rx_pkg::*;
#(
  parameter int MISS_LIMIT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic lineClk,
  input  logic pcmClk,
  input  logic rstN,
  input  logic railPosN,
  input  logic railNegN,
  input  logic holdOnMiss,
  input  logic forceOnes,
  input  logic envA,
  input  logic envB,
  input  logic envSelA,
  output logic pcmOut,
  output logic alarm,
  output logic repeatFlag,
  output logic deleteFlag
);
  lineStrobe_t lStb;
  slotStrobe_t sStb;
  logic wrTog;

  codir_line_ctrl #(.MISS_LIMIT(MISS_LIMIT)) uLine (
    .lineClk(lineClk), .rstN(rstN), .railPosN(railPosN), .railNegN(railNegN),
    .holdOnMiss(holdOnMiss), .strobe(lStb), .alarm(alarm)
  );

  codir_slot_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uSlot (
    .pcmClk(pcmClk), .rstN(rstN), .envA(envA), .envB(envB), .envSelA(envSelA),
    .wrTog(wrTog), .strobe(sStb), .repeatFlag(repeatFlag), .deleteFlag(deleteFlag)
  );

  codir_octet_path uPath (
    .lineClk(lineClk), .pcmClk(pcmClk), .rstN(rstN), .lStb(lStb), .sStb(sStb),
    .forceOnes(forceOnes), .wrTog(wrTog), .pcmOut(pcmOut)
  );
endmodule

// File: tb/tb_codir_rx_aligner.sv
module tb_codir_rx_aligner;
  logic pcmClk = 1'b0, lineClk = 1'b0;
  always #2 pcmClk  = ~pcmClk;
  always #5 lineClk = ~lineClk;

  logic rstN, railPosN, railNegN, holdOnMiss, forceOnes, envA, envB, envSelA;
  logic pcmOut, alarm, repeatFlag, deleteFlag;

  codir_rx_aligner dut (
    .lineClk(lineClk), .pcmClk(pcmClk), .rstN(rstN), .railPosN(railPosN), .railNegN(railNegN),
    .holdOnMiss(holdOnMiss), .forceOnes(forceOnes), .envA(envA), .envB(envB), .envSelA(envSelA),
    .pcmOut(pcmOut), .alarm(alarm), .repeatFlag(repeatFlag), .deleteFlag(deleteFlag)
  );

  int checks = 0, errors = 0;
  logic [7:0] expVal [0:511];
  int sentCount = 0, lastIdx = -1, repSeen = 0, delSeen = 0;
  int lenMin = 38, lenMax = 42, decoyCnt = 0, forceCnt = 0;
  bit synced = 1'b1, genOn = 1'b0, wantSelA = 1'b1, lastRail = 1'b0;
  logic [7:0] prevVal = 8'hFF;
  int offs;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dataFor(int i);
    return 8'((i * 97 + offs) & 255);
  endfunction

  // one bit, two half-bit samples; rail 1 = positive
  task automatic sendBit(bit v, bit rail);
    @(negedge lineClk);
    railPosN = !rail; railNegN = rail;
    @(negedge lineClk);
    if (v) begin railPosN = 1'b1; railNegN = 1'b1; end
  endtask

  task automatic sendOctet(logic [7:0] d, bit viol);
    expVal[sentCount] = (!viol && !holdOnMiss) ? 8'hFF : d;
    sentCount++;
    for (int b = 0; b < 8; b++) begin
      bit r;
      r = (b == 7 && viol) ? lastRail : ~lastRail;
      sendBit(d[b], r);
      lastRail = r;
    end
  endtask

  task automatic lineIdle(int n);
    @(negedge lineClk);
    railPosN = 1'b1; railNegN = 1'b1;
    repeat (n) @(negedge lineClk);
  endtask

  task automatic processFrame(logic [7:0] val, bit rep, bit del);
    if (!synced) begin
      for (int k = sentCount - 1; k >= 0 && k >= sentCount - 4; k--)
        if (!synced && expVal[k] == val) begin synced = 1'b1; lastIdx = k; end
    end else if (rep) begin
      check(val == prevVal && !del, "R9 repeated octet", val, prevVal);
      repSeen++;
    end else if (del) begin
      int hit = -1;
      for (int d = 2; d <= 4; d++)
        if (hit < 0 && lastIdx + d < sentCount && expVal[lastIdx + d] == val) hit = lastIdx + d;
      check(hit >= 0, "R10 newest octet after drop", val,
            (lastIdx + 2 < sentCount) ? expVal[lastIdx + 2] : 0);
      delSeen++;
      if (hit >= 0) lastIdx = hit;
    end else begin
      logic [7:0] e;
      e = (lastIdx + 1 < sentCount) ? expVal[lastIdx + 1] : 8'h00;
      check(lastIdx + 1 < sentCount && val === e, "R2 R5 R6 R10 delivered octet", val, e);
      lastIdx++;
    end
    prevVal = val;
  endtask

  // envelope generator and burst monitor
  initial begin
    envA = 1'b0; envB = 1'b0; forceOnes = 1'b0; envSelA = 1'b1;
    forever begin
      if (!genOn) begin
        @(negedge pcmClk);
      end else begin
        int len;
        bit decoy, forced, rep, del;
        logic [7:0] val;
        envSelA = wantSelA;
        decoy  = decoyCnt > 0; if (decoy)  decoyCnt--;
        forced = forceCnt > 0; if (forced) forceCnt--;
        len = lenMin + int'($urandom % 32'(lenMax - lenMin + 1));
        @(negedge pcmClk);
        forceOnes = forced;
        if (decoy ^ envSelA) envA = 1'b1; else envB = 1'b1;
        for (int i = 0; i < 8; i++) begin
          @(negedge pcmClk);
          val[i] = pcmOut;
          if (i == 0) begin rep = repeatFlag; del = deleteFlag; end
        end
        envA = 1'b0; envB = 1'b0; forceOnes = 1'b0;
        @(negedge pcmClk);
        check(pcmOut == 1'b1, "R3 idle high after burst", pcmOut, 1);
        if (decoy) check(val == 8'hFF, "R4 unselected envelope ignored", val, 8'hFF);
        else if (forced) begin
          check(val == 8'hFF, "R8 forced ones", val, 8'hFF);
          synced = 1'b0;
        end else processFrame(val, rep, del);
        repeat (len - 10) @(negedge pcmClk);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge pcmClk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    offs = int'($urandom % 256);
    rstN = 1'b0; railPosN = 1'b1; railNegN = 1'b1; holdOnMiss = 1'b1;
    repeat (5) @(negedge lineClk);
    check(pcmOut == 1'b1, "R1 reset pcmOut", pcmOut, 1);
    check(alarm == 1'b0, "R1 reset alarm", alarm, 0);
    check(repeatFlag == 1'b0 && deleteFlag == 1'b0, "R1 reset flags", {repeatFlag, deleteFlag}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge lineClk);
    genOn = 1'b1;

    // matched rate, envelope A, directed decode corners then random
    decoyCnt = 2;
    sendOctet(8'h00, 1'b1); sendOctet(8'hFF, 1'b1);
    sendOctet(8'h01, 1'b1); sendOctet(8'h80, 1'b1);
    for (int i = 0; i < 12; i++) sendOctet(dataFor(sentCount), 1'b1);
    // envelope B
    wantSelA = 1'b0; decoyCnt = 2;
    for (int i = 0; i < 12; i++) sendOctet(dataFor(sentCount), 1'b1);
    lineIdle(20);
    wantSelA = 1'b1;

    // fast local clock: repeats
    repSeen = 0; lenMin = 20; lenMax = 26;
    for (int i = 0; i < 15; i++) sendOctet(dataFor(sentCount), 1'b1);
    check(repSeen > 0, "R9 repeats seen under fast bursts", repSeen, 1);

    // slow local clock: drops
    delSeen = 0; lenMin = 85; lenMax = 95;
    for (int i = 0; i < 15; i++) sendOctet(dataFor(sentCount), 1'b1);
    check(delSeen > 0, "R10 drops seen under slow bursts", delSeen, 1);
    lenMin = 38; lenMax = 42;

    // missing markers, pass-through
    holdOnMiss = 1'b1;
    for (int i = 0; i < 6; i++) sendOctet(dataFor(sentCount), 1'b0);
    lineIdle(3);
    check(alarm == 1'b0, "R7 no alarm after six misses", alarm, 0);
    sendOctet(dataFor(sentCount), 1'b1);

    // missing markers, blanked, alarm boundary
    holdOnMiss = 1'b0;
    for (int i = 0; i < 7; i++) sendOctet(dataFor(sentCount), 1'b0);
    lineIdle(3);
    check(alarm == 1'b0, "R7 no alarm after seven misses", alarm, 0);
    sendOctet(dataFor(sentCount), 1'b0);
    lineIdle(3);
    check(alarm == 1'b1, "R7 alarm after eighth miss", alarm, 1);
    sendOctet(dataFor(sentCount), 1'b0);
    lineIdle(3);
    check(alarm == 1'b1, "R7 alarm held", alarm, 1);
    sendOctet(dataFor(sentCount), 1'b1);
    lineIdle(3);
    check(alarm == 1'b0, "R7 alarm cleared by marker", alarm, 0);
    holdOnMiss = 1'b1;
    for (int i = 0; i < 4; i++) sendOctet(dataFor(sentCount), 1'b1);

    // forced ones then resync
    forceCnt = 3;
    for (int i = 0; i < 10; i++) sendOctet(dataFor(sentCount), 1'b1);
    lineIdle(30);
    check(synced, "R8 stream resumes after forced ones", synced, 1);

    genOn = 1'b0;
    repeat (100) @(negedge pcmClk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule